// File: doc/BRIEF.md
# USB Device Interrupt Flag Register

This block gathers the event indications of a USB device-mode engine into one 16-bit word of sticky flags. Each flag is raised by hardware and lowered by software writing a one into its position. Most flags are raised directly by single-cycle event pulses from the packet engine: stall handshake sent, token done, start-of-frame seen or frame threshold reached, and bus errors. Three flags come from persistence timers inside the block that watch the sampled line state: bus idle, resume signalling and bus reset.

The token-done flag sits in front of a small queue of transaction status words. Every finished token pushes its status word. Software reads the head entry. Clearing the token-done flag discards that head. If more entries are waiting, the flag comes back one cycle later. The error flag is a read-only summary: it rises only for error pulses that an error-enable mask allows, and a write cannot clear it. A single interrupt line is driven high when any flag is set and enabled by an interrupt-enable mask.

Top module: `usbd_irq_status`

## Requirements
- R1: Flag positions in `flags_o` are: bit 0 bus reset, bit 1 error summary, bit 2 start-of-frame, bit 3 token done, bit 4 idle, bit 5 resume, bit 7 stall sent. Bit 6 and bits 15..8 always read 0.
- R2: During a write (`wr_en_i`=1), each clearable flag whose bit in `wr_data_i` is 1 reads 0 from the next cycle on. A flag whose write bit is 0 keeps its value.
- R3: When a flag's hardware set and its clear by write fall in the same cycle, the flag reads 1 afterwards.
- R4: The error flag (bit 1) sets one cycle after any bit of `err_vec_i` is 1 while the matching bit of `err_en_i` is 1. Error pulses with a disabled bit do not set it. Writes never clear it.
- R5: An `ev_tok_i` pulse sets the token flag and queues `tok_stat_i`. `stat_o` shows the oldest queued word while `stat_valid_o` is 1. Clearing the token flag removes that word. If words remain, the flag reads 1 again one cycle after the clear. The queue holds FIFO_DEPTH words, and pushes into a full queue are dropped.
- R6: The idle flag sets after `line_state_i` has shown the J state for IDLE_CYC consecutive cycles. J is 2'b01 at full speed and 2'b10 at low speed. Any other line value restarts the count.
- R7: The resume flag sets after the K state has shown for RESUME_CYC consecutive cycles. K is 2'b10 at full speed (`low_speed_i`=0) and 2'b01 at low speed.
- R8: The bus-reset flag sets after SE0 (2'b00) has been held for RST_CYC consecutive cycles. If it is cleared while SE0 persists, it stays 0 until the line leaves SE0 and a new SE0 period of RST_CYC cycles completes.
- R9: The start-of-frame flag sets on either a `sof_tok_i` pulse or a `sof_thr_i` pulse.
- R10: `irq_o` is 1 exactly when some bit of `flags_o` AND `irq_en_i` is 1, in the same cycle.
- R11: While `rst_n` is 0, `flags_o`, `irq_o` and `stat_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_speed_i | input | 1 | 1 selects low-speed line polarity |
| line_state_i | input | 2 | Sampled line: 00 SE0, 01 D+ high, 10 D- high, 11 SE1 |
| ev_stall_i | input | 1 | Pulse: stall handshake was sent |
| ev_tok_i | input | 1 | Pulse: token processing finished |
| tok_stat_i | input | STAT_W | Status word queued with `ev_tok_i` |
| sof_tok_i | input | 1 | Pulse: start-of-frame token received |
| sof_thr_i | input | 1 | Pulse: frame threshold count reached |
| err_vec_i | input | ERR_W | Error condition pulses |
| err_en_i | input | ERR_W | Error enable mask |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 16 | Write data; ones clear flags |
| irq_en_i | input | 16 | Interrupt enable mask |
| flags_o | output | 16 | Flag word |
| irq_o | output | 1 | Interrupt request |
| stat_o | output | STAT_W | Head of the status queue (0 when empty) |
| stat_valid_o | output | 1 | Status queue holds at least one word |

## Verification
The bench goes after the edges of the timers. It samples one cycle before and one cycle after each threshold, so a timer that is off by one cycle would set its flag early or late. It re-runs the idle count after a one-cycle break to catch a timer that does not restart. It also holds SE0 for a long time after clearing the reset flag, where a timer that re-arms would raise the flag a second time. For the status queue, it fills past capacity and drains. A queue with the wrong depth, one that lost or repeated entries, or one whose flag did not come back after a clear would show the wrong head or validity. Same-cycle set and clear, read-modify-write of the whole word, and a write to the error bit would expose a clear that wins, a write-zero that clears, and an error flag that a write could drop.

// File: rtl/usbd_irq_pkg.sv
`timescale 1ns/1ps
package usbd_irq_pkg;
   localparam int REG_W   = 16;
   localparam int B_BRST  = 0;
   localparam int B_ERR   = 1;
   localparam int B_SOF   = 2;
   localparam int B_TOK   = 3;
   localparam int B_IDLE  = 4;
   localparam int B_RSM   = 5;
   localparam int B_STALL = 7;

   // positions that hold a flag, and positions a write may clear
   localparam logic [REG_W-1:0] IMPL_MASK = 16'h00BF;
   localparam logic [REG_W-1:0] CLR_MASK  = 16'h00BD;

   // sampled line codes
   localparam logic [1:0] LN_SE0   = 2'b00;
   localparam logic [1:0] LN_DPLUS = 2'b01;
   localparam logic [1:0] LN_DMIN  = 2'b10;
   localparam logic [1:0] LN_SE1   = 2'b11;
endpackage

// File: rtl/usbd_persist_timer.sv
`timescale 1ns/1ps
// Counts consecutive cycles with cond_i high; emits one pulse on the
// LIMIT-th such cycle, then saturates until cond_i drops.
module usbd_persist_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   output logic hit_o
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("usbd_persist_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!cond_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(LIMIT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = cond_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/usbd_tok_fifo.sv
`timescale 1ns/1ps
module usbd_tok_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push_i,
   input  logic [W-1:0] push_data_i,
   input  logic         pop_i,
   output logic [W-1:0] head_o,
   output logic         valid_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("usbd_tok_fifo: DEPTH must be a power of two, at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("usbd_tok_fifo: W must be positive");
   end

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] rd_q, wr_q;
   logic [AW:0]   cnt_q;
   logic          full, do_pop, do_push;

   assign full    = (cnt_q == FULL_CNT);
   assign do_pop  = pop_i && (cnt_q != '0);
   assign do_push = push_i && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem_q[wr_q] <= push_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= wr_q + 1'b1;
         if (do_pop)  rd_q <= rd_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign valid_o = (cnt_q != '0);
   assign head_o  = valid_o ? mem_q[rd_q] : '0;
endmodule

// File: rtl/usbd_w1c_bit.sv
`timescale 1ns/1ps
module usbd_w1c_bit #(
   parameter bit CLEARABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic clr_eff;

   assign clr_eff = clr_i & CLEARABLE;

   // set has priority over clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= set_i | (q_o & ~clr_eff);
   end
endmodule

// File: rtl/usbd_irq_status.sv
`timescale 1ns/1ps
module usbd_irq_status
   import usbd_irq_pkg::*;
#(
   parameter int CLK_KHZ    = 48000,
   parameter int IDLE_CYC   = CLK_KHZ * 3,
   parameter int RESUME_CYC = (CLK_KHZ * 25) / 10000,
   parameter int RST_CYC    = (CLK_KHZ * 25) / 10000,
   parameter int FIFO_DEPTH = 4,
   parameter int STAT_W     = 8,
   parameter int ERR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              low_speed_i,
   input  logic [1:0]        line_state_i,
   input  logic              ev_stall_i,
   input  logic              ev_tok_i,
   input  logic [STAT_W-1:0] tok_stat_i,
   input  logic              sof_tok_i,
   input  logic              sof_thr_i,
   input  logic [ERR_W-1:0]  err_vec_i,
   input  logic [ERR_W-1:0]  err_en_i,
   input  logic              wr_en_i,
   input  logic [REG_W-1:0]  wr_data_i,
   input  logic [REG_W-1:0]  irq_en_i,
   output logic [REG_W-1:0]  flags_o,
   output logic              irq_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              stat_valid_o
);
   if (ERR_W < 1 || STAT_W < 1) begin : g_bad_width
      $error("usbd_irq_status: ERR_W and STAT_W must be positive");
   end

   logic [1:0]       j_code, k_code;
   logic             idle_hit, rsm_hit, brst_hit;
   logic             fifo_valid, fifo_pop;
   logic [REG_W-1:0] set_vec, clr_vec, flag_vec;
   logic             unused_bits;

   // line polarity depends on speed
   assign j_code = low_speed_i ? LN_DMIN  : LN_DPLUS;
   assign k_code = low_speed_i ? LN_DPLUS : LN_DMIN;

   usbd_persist_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (line_state_i == j_code),
      .hit_o  (idle_hit)
   );

   usbd_persist_timer #(.LIMIT(RESUME_CYC)) u_rsm_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (line_state_i == k_code),
      .hit_o  (rsm_hit)
   );

   // saturating count gives one set per SE0 episode
   usbd_persist_timer #(.LIMIT(RST_CYC)) u_brst_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .cond_i (line_state_i == LN_SE0),
      .hit_o  (brst_hit)
   );

   assign fifo_pop = wr_en_i & wr_data_i[B_TOK] & flag_vec[B_TOK];

   usbd_tok_fifo #(.DEPTH(FIFO_DEPTH), .W(STAT_W)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (ev_tok_i),
      .push_data_i (tok_stat_i),
      .pop_i       (fifo_pop),
      .head_o      (stat_o),
      .valid_o     (fifo_valid)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[B_BRST]  = brst_hit;
      set_vec[B_ERR]   = |(err_vec_i & err_en_i);
      set_vec[B_SOF]   = sof_tok_i | sof_thr_i;
      // re-raise while entries wait behind a cleared head
      set_vec[B_TOK]   = ev_tok_i | (fifo_valid & ~flag_vec[B_TOK]);
      set_vec[B_IDLE]  = idle_hit;
      set_vec[B_RSM]   = rsm_hit;
      set_vec[B_STALL] = ev_stall_i;
   end

   assign clr_vec = wr_en_i ? (wr_data_i & CLR_MASK) : '0;

   for (genvar b = 0; b < REG_W; b++) begin : g_flag
      if (IMPL_MASK[b]) begin : g_impl
         usbd_w1c_bit #(.CLEARABLE(CLR_MASK[b])) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[b]),
            .clr_i (clr_vec[b]),
            .q_o   (flag_vec[b])
         );
      end else begin : g_rsvd
         assign flag_vec[b] = 1'b0;
      end
   end

   assign unused_bits  = ^{set_vec & ~IMPL_MASK, clr_vec & ~IMPL_MASK};
   assign flags_o      = flag_vec;
   assign irq_o        = |(flag_vec & irq_en_i);
   assign stat_valid_o = fifo_valid;
endmodule

// File: rtl/usbd_irq_status_chk.sv
`timescale 1ns/1ps
module usbd_irq_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  line_state_i,
   input logic        wr_en_i,
   input logic [15:0] wr_data_i,
   input logic        ev_stall_i,
   input logic [15:0] flags_o,
   input logic        stat_valid_o
);
   assert_unimpl_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[15:8] == 8'h00) && !flags_o[6]);

   assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[7] && !ev_stall_i) |=> !flags_o[7]);

   assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[7] && !(wr_en_i && wr_data_i[7])) |=> flags_o[7]);

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stall_i |=> flags_o[7]);

   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[1] |=> flags_o[1]);

   assert_tok_reraise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid_o && !flags_o[3]) |=> flags_o[3]);

   assert_brst_no_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flags_o[0]) && !flags_o[0] && (line_state_i == 2'b00)) |=> !flags_o[0]);
endmodule

bind usbd_irq_status usbd_irq_status_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .line_state_i (line_state_i),
   .wr_en_i      (wr_en_i),
   .wr_data_i    (wr_data_i),
   .ev_stall_i   (ev_stall_i),
   .flags_o      (flags_o),
   .stat_valid_o (stat_valid_o)
);

// File: tb/tb_usbd_irq_status.sv
`timescale 1ns/1ps
module tb_usbd_irq_status;
   localparam int IDLE_N = 20;
   localparam int RSM_N  = 6;
   localparam int RST_N  = 8;
   localparam int NV     = 15;

   // {wr_en, wr_data[7:0], stall, sof, err_vec[3:0], expected flags[7:0]}
   // err_en is 4'b0101 for the whole table
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, 8'h00, 1'b1, 1'b0, 4'h0, 8'h80},  // R1 stall sets bit 7
      {1'b0, 8'h00, 1'b0, 1'b1, 4'h0, 8'h84},  // R9 sof sets bit 2
      {1'b1, 8'h04, 1'b0, 1'b0, 4'h0, 8'h80},  // R2 clear sof
      {1'b1, 8'h00, 1'b0, 1'b0, 4'h0, 8'h80},  // R2 zero write keeps
      {1'b0, 8'h00, 1'b0, 1'b0, 4'h2, 8'h80},  // R4 disabled error
      {1'b0, 8'h00, 1'b0, 1'b0, 4'h1, 8'h82},  // R4 enabled error
      {1'b1, 8'hFF, 1'b0, 1'b0, 4'h0, 8'h02},  // R4 error survives write
      {1'b1, 8'h80, 1'b1, 1'b0, 4'h0, 8'h82},  // R3 set beats clear
      {1'b1, 8'h82, 1'b0, 1'b0, 4'h0, 8'h02},  // R2 read-modify-write
      {1'b1, 8'h04, 1'b0, 1'b1, 4'h0, 8'h06},  // R3 sof set beats clear
      {1'b1, 8'h04, 1'b0, 1'b0, 4'h0, 8'h02},  // R2
      {1'b1, 8'h02, 1'b0, 1'b0, 4'h4, 8'h02},  // R4 enabled error with write
      {1'b0, 8'h00, 1'b1, 1'b1, 4'h0, 8'h86},  // R1 two events
      {1'b1, 8'h00, 1'b0, 1'b0, 4'h0, 8'h86},  // R2
      {1'b1, 8'h84, 1'b0, 1'b0, 4'h0, 8'h02}   // R2
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        low_speed = 1'b0;
   logic [1:0]  line = 2'b11;
   logic        ev_stall = 1'b0, ev_tok = 1'b0, sof_tok = 1'b0, sof_thr = 1'b0;
   logic [7:0]  tok_stat = 8'h00;
   logic [3:0]  err_vec = 4'h0, err_en = 4'h5;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = 16'h0000, irq_en = 16'hFFFF;
   logic [15:0] flags;
   logic        irq, stat_valid;
   logic [7:0]  stat;
   int          n_chk = 0, n_err = 0;

   always #2 clk = ~clk;

   usbd_irq_status #(
      .IDLE_CYC(IDLE_N), .RESUME_CYC(RSM_N), .RST_CYC(RST_N),
      .FIFO_DEPTH(4), .STAT_W(8), .ERR_W(4)
   ) dut (
      .clk(clk), .rst_n(rst_n), .low_speed_i(low_speed), .line_state_i(line),
      .ev_stall_i(ev_stall), .ev_tok_i(ev_tok), .tok_stat_i(tok_stat),
      .sof_tok_i(sof_tok), .sof_thr_i(sof_thr), .err_vec_i(err_vec),
      .err_en_i(err_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .irq_en_i(irq_en), .flags_o(flags), .irq_o(irq), .stat_o(stat),
      .stat_valid_o(stat_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      #1;
      wr_en = 1'b0; wr_data = 16'h0000; ev_stall = 1'b0; ev_tok = 1'b0;
      sof_tok = 1'b0; sof_thr = 1'b0; err_vec = 4'h0;
      @(negedge clk);
   endtask

   task automatic hold(input int n);
      for (int k = 0; k < n; k++) cycle();
   endtask

   task automatic wr(input logic [15:0] d);
      wr_en = 1'b1;
      wr_data = d;
      cycle();
   endtask

   task automatic push(input logic [7:0] s);
      ev_tok = 1'b1;
      tok_stat = s;
      cycle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 flags", 32'(flags), 32'h0);
      chk("R11 irq", 32'(irq), 32'h0);
      chk("R11 valid", 32'(stat_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         wr_en    = VEC[i][22];
         wr_data  = {8'h00, VEC[i][21:14]};
         ev_stall = VEC[i][13];
         sof_tok  = VEC[i][12];
         err_vec  = VEC[i][11:8];
         cycle();
         chk("R1|R2|R3|R4|R9 table flags", 32'(flags), 32'(VEC[i][7:0]));
         chk("R10 table irq", 32'(irq), 32'(|VEC[i][7:0]));
      end

      // R9 threshold source
      sof_thr = 1'b1;
      cycle();
      chk("R9 threshold", 32'(flags), 32'h06);
      wr(16'h0004);

      // R10 masking
      irq_en = 16'h0000; #1;
      chk("R10 mask none", 32'(irq), 32'h0);
      irq_en = 16'h0002; #1;
      chk("R10 mask err", 32'(irq), 32'h1);
      irq_en = 16'h0004; #1;
      chk("R10 mask sof", 32'(irq), 32'h0);
      irq_en = 16'hFFFF;
      @(negedge clk);

      // R5 status queue
      push(8'h11);
      chk("R5 tok flag", 32'(flags[3]), 32'h1);
      chk("R5 head", 32'(stat), 32'h11);
      push(8'h22);
      push(8'h33);
      wr(16'h0008);
      chk("R5 flag after clear", 32'(flags[3]), 32'h0);
      chk("R5 head advance", 32'(stat), 32'h22);
      cycle();
      chk("R5 reraise", 32'(flags[3]), 32'h1);
      wr(16'h0008);
      chk("R5 head 3", 32'(stat), 32'h33);
      cycle();
      wr(16'h0008);
      chk("R5 empty", 32'(stat_valid), 32'h0);
      cycle();
      chk("R5 no reraise", 32'(flags[3]), 32'h0);
      for (int j = 0; j < 5; j++) push(8'hA0 + 8'(j));
      for (int j = 0; j < 4; j++) begin
         chk("R5 full flag", 32'(flags[3]), 32'h1);
         chk("R5 full head", 32'(stat), 32'(8'hA0 + 8'(j)));
         wr(16'h0008);
         cycle();
      end
      chk("R5 overflow dropped", 32'(stat_valid), 32'h0);
      chk("R5 flag low", 32'(flags[3]), 32'h0);

      // R6 idle, full speed J = 01
      low_speed = 1'b0;
      line = 2'b01;
      hold(IDLE_N - 1);
      chk("R6 idle early", 32'(flags[4]), 32'h0);
      chk("R7 J is not K", 32'(flags[5]), 32'h0);
      cycle();
      chk("R6 idle set", 32'(flags[4]), 32'h1);
      wr(16'h0010);
      hold(5);
      chk("R6 idle one shot", 32'(flags[4]), 32'h0);
      line = 2'b11; cycle();
      line = 2'b01; hold(IDLE_N - 2);
      line = 2'b11; cycle();
      line = 2'b01; hold(IDLE_N - 1);
      chk("R6 idle restarted", 32'(flags[4]), 32'h0);
      cycle();
      chk("R6 idle after restart", 32'(flags[4]), 32'h1);
      wr(16'h0010);

      // R7 resume, low speed K = 01
      line = 2'b11; cycle();
      low_speed = 1'b1;
      line = 2'b01;
      hold(RSM_N - 1);
      chk("R7 resume early", 32'(flags[5]), 32'h0);
      cycle();
      chk("R7 resume LS", 32'(flags[5]), 32'h1);
      wr(16'h0020);
      chk("R7 cleared", 32'(flags[5]), 32'h0);
      line = 2'b11; low_speed = 1'b0; cycle();
      line = 2'b10;
      hold(RSM_N);
      chk("R7 resume FS", 32'(flags[5]), 32'h1);
      chk("R6 K is not idle", 32'(flags[4]), 32'h0);
      wr(16'h0020);

      // R8 bus reset
      line = 2'b00;
      hold(RST_N - 1);
      chk("R8 reset early", 32'(flags[0]), 32'h0);
      cycle();
      chk("R8 reset set", 32'(flags[0]), 32'h1);
      chk("R1 unimplemented zero", 32'(flags & 16'hFF40), 32'h0);
      wr(16'h0001);
      chk("R8 cleared", 32'(flags[0]), 32'h0);
      hold(3 * RST_N);
      chk("R8 no re-set while SE0", 32'(flags[0]), 32'h0);
      line = 2'b11; cycle();
      line = 2'b00;
      hold(RST_N);
      chk("R8 new episode", 32'(flags[0]), 32'h1);
      line = 2'b11;
      wr(16'hFFFF);
      chk("R1|R4 final word", 32'(flags), 32'h0002);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule